// File: doc/BRIEF.md
# Five-Source Nested Interrupt Arbiter

This block collects interrupt requests for a small tuning-controller core and hands the core one vector at a time. There are five sources. Two are external pins, and each pin can be set to react to either a rising or a falling edge. The third is a one-cycle "serial transfer finished" strobe. The last two are periodic timers, each with its own run bit and a choice of eight periods. Every source owns a sticky pending flag and an enable bit. The enabled pending source with the highest priority is offered as a vector index. The core takes that vector with an acknowledge strobe and later ends the handler with a return strobe.

Accepted vectors go onto a small nesting stack. A new request is offered only when its priority is strictly above the level now in service and the stack still has room. A wake output is raised while any enabled request is pending, or while the single external wake input is high. Wake does not depend on nesting depth, so the core can leave halt mode from it.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `irq_req` is low, `nest_depth` is 0, and `wake` is low while `ext_wake` is low.
- R2: A pin whose `ext_rise_sel` bit is 1 latches a request on a low-to-high change. When that bit is 0, the pin latches on a high-to-low change. A change in the other direction latches nothing.
- R3: Changing an `ext_rise_sel` bit while the pin level stays constant latches no request.
- R4: Vector codes are 0 for pin 0, 1 for pin 1, 2 for serial done, 3 for timer 0 and 4 for timer 1. When several enabled requests are pending, the lowest code is offered.
- R5: A source whose `src_en` bit (bit n for code n) is 0 is never offered, but its pending flag stays set. Setting the bit later offers the request.
- R6: An acknowledge while `irq_req` is high and `irq_ret` is low does three things: it clears the offered source's flag, pushes its code, and raises `nest_depth` by one.
- R7: While a handler is in service, only a pending source with a lower code than the one in service is offered. An equal or higher code waits until a return.
- R8: `nest_depth` never exceeds DEPTH (4 by default). At full depth no request is offered, and the waiting request stays pending.
- R9: A return pops one level and restores the previous service level. A return at depth 0 has no effect.
- R10: Timer period select codes 0 to 7 choose 1, 10, 20, 50, 100, 500, 1250 and 2500 base ticks. A base tick is TICK_DIV clocks (450 clocks of a 4.5 MHz clock is 100 µs). While a timer runs, its requests are exactly that many clocks apart.
- R11: `wake` is high exactly when some enabled source is pending or `ext_wake` is high. This holds at any nesting depth.
- R12: A timer whose run bit is low raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 2 | External interrupt pins, asynchronous |
| ext_rise_sel | input | 2 | Per pin: 1 selects rising edge, 0 selects falling edge |
| ser_done | input | 1 | Serial transfer complete strobe |
| tmr_run | input | 2 | Run bit for each timer |
| tmr0_sel | input | 3 | Timer 0 period code |
| tmr1_sel | input | 3 | Timer 1 period code |
| src_en | input | 5 | Per-source enable, bit n for vector code n |
| irq_ack | input | 1 | Core takes the offered vector |
| irq_ret | input | 1 | Core returns from the current handler |
| ext_wake | input | 1 | Extra wake source (key or hold input) |
| irq_req | output | 1 | A vector is offered |
| irq_vec | output | 3 | Offered vector code |
| nest_depth | output | 3 | Handlers currently in service |
| wake | output | 1 | Halt release |

## Verification
The bench builds the block with DEPTH=4, SYNC_STAGES=2 and TICK_DIV=3. Shrinking the base tick to three clocks puts the longest period (2500 ticks) within about 7500 cycles, so all eight period codes are measured exactly against their tick multiples. A nesting depth of four is the smallest that lets all five sources stack in strictly rising priority and still leave the highest one blocked at the limit.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
   localparam int NSRC     = 5;
   localparam int VW       = 3;
   localparam int MAX_MULT = 2500;

   typedef logic [VW-1:0] vec_t;

   localparam vec_t VEC_PIN0 = 3'd0;
   localparam vec_t VEC_PIN1 = 3'd1;
   localparam vec_t VEC_SER  = 3'd2;
   localparam vec_t VEC_TMR0 = 3'd3;
   localparam vec_t VEC_TMR1 = 3'd4;
   localparam vec_t VEC_NONE = 3'd5;

   // base ticks per period code
   function automatic int unsigned period_mult(input logic [2:0] sel);
      case (sel)
         3'd0:    period_mult = 1;
         3'd1:    period_mult = 10;
         3'd2:    period_mult = 20;
         3'd3:    period_mult = 50;
         3'd4:    period_mult = 100;
         3'd5:    period_mult = 500;
         3'd6:    period_mult = 1250;
         default: period_mult = 2500;
      endcase
   endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   output logic evt
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   lvl;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign lvl = sync_q[SYNC_STAGES-1];
   // event depends on a level change only, never on the polarity bit alone
   assign evt = rise_sel ? (lvl & ~prev_q) : (~lvl & prev_q);
endmodule

// File: rtl/irq_period_timer.sv
module irq_period_timer
   import irq_nest_pkg::*;
#(
   parameter int TICK_DIV = 450
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] sel,
   output logic       fire
);
   localparam int PW = $clog2(TICK_DIV);
   localparam int TW = $clog2(MAX_MULT);

   logic [PW-1:0] pre_q;
   logic [TW-1:0] tick_q;
   logic [TW-1:0] lim;
   logic          pre_end;

   if (TICK_DIV < 2) begin : g_bad_div
      $error("TICK_DIV must be at least 2");
   end

   assign lim     = TW'(period_mult(sel) - 1);
   assign pre_end = (pre_q == PW'(TICK_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         tick_q <= '0;
         fire   <= 1'b0;
      end else if (!run) begin
         pre_q  <= '0;
         tick_q <= '0;
         fire   <= 1'b0;
      end else begin
         fire <= 1'b0;
         if (pre_end) begin
            pre_q <= '0;
            if (tick_q >= lim) begin
               tick_q <= '0;
               fire   <= 1'b1;
            end else begin
               tick_q <= tick_q + 1'b1;
            end
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N  = 5,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   output logic          valid,
   output logic [IW-1:0] idx
);
   always_comb begin
      valid = |req;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
   import irq_nest_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int DW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  vec_t          push_lvl,
   input  logic          pop,
   output logic [DW-1:0] depth,
   output vec_t          cur_lvl,
   output logic          full
);
   vec_t          stk_q [DEPTH];
   logic [DW-1:0] dep_q;
   logic          do_pop;
   logic          do_push;

   assign full    = (dep_q == DW'(DEPTH));
   assign do_pop  = pop && (dep_q != '0);
   assign do_push = push && !pop && !full;
   assign depth   = dep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dep_q <= '0;
      else if (do_pop)  dep_q <= dep_q - 1'b1;
      else if (do_push) dep_q <= dep_q + 1'b1;
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               stk_q[g] <= VEC_NONE;
         else if (do_push && dep_q == DW'(g))      stk_q[g] <= push_lvl;
      end
   end

   always_comb begin
      cur_lvl = VEC_NONE;
      for (int i = 0; i < DEPTH; i++) begin
         if (dep_q == DW'(i + 1)) cur_lvl = stk_q[i];
      end
   end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
   import irq_nest_pkg::*;
#(
   parameter int DEPTH       = 4,
   parameter int TICK_DIV    = 450,
   parameter int SYNC_STAGES = 2,
   localparam int DW         = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    ext_pin,
   input  logic [1:0]    ext_rise_sel,
   input  logic          ser_done,
   input  logic [1:0]    tmr_run,
   input  logic [2:0]    tmr0_sel,
   input  logic [2:0]    tmr1_sel,
   input  logic [4:0]    src_en,
   input  logic          irq_ack,
   input  logic          irq_ret,
   input  logic          ext_wake,
   output logic          irq_req,
   output logic [2:0]    irq_vec,
   output logic [DW-1:0] nest_depth,
   output logic          wake
);
   if (DEPTH < 1 || DEPTH > 7) begin : g_bad_depth
      $error("DEPTH must lie in 1..7");
   end

   logic [1:0]      ext_evt;
   logic [1:0]      tmr_fire;
   logic [2:0]      tmr_sel [2];
   logic [NSRC-1:0] set_evt;
   logic [NSRC-1:0] pend_q;
   logic [NSRC-1:0] masked;
   logic            win_valid;
   vec_t            win_idx;
   vec_t            cur_lvl;
   logic            full;
   logic            take;

   assign tmr_sel[0] = tmr0_sel;
   assign tmr_sel[1] = tmr1_sel;

   for (genvar g = 0; g < 2; g++) begin : g_pin
      irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin      (ext_pin[g]),
         .rise_sel (ext_rise_sel[g]),
         .evt      (ext_evt[g])
      );
   end

   for (genvar g = 0; g < 2; g++) begin : g_tmr
      irq_period_timer #(.TICK_DIV(TICK_DIV)) u_tmr (
         .clk   (clk),
         .rst_n (rst_n),
         .run   (tmr_run[g]),
         .sel   (tmr_sel[g]),
         .fire  (tmr_fire[g])
      );
   end

   assign set_evt = {tmr_fire[1], tmr_fire[0], ser_done, ext_evt[1], ext_evt[0]};
   assign take    = irq_req && irq_ack && !irq_ret;

   for (genvar g = 0; g < NSRC; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             pend_q[g] <= 1'b0;
         else if (set_evt[g])                    pend_q[g] <= 1'b1;
         else if (take && win_idx == vec_t'(g))  pend_q[g] <= 1'b0;
      end
   end

   assign masked = pend_q & src_en;

   irq_prio_pick #(.N(NSRC), .IW(VW)) u_pick (
      .req   (masked),
      .valid (win_valid),
      .idx   (win_idx)
   );

   irq_nest_stack #(.DEPTH(DEPTH), .DW(DW)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (take),
      .push_lvl (win_idx),
      .pop      (irq_ret),
      .depth    (nest_depth),
      .cur_lvl  (cur_lvl),
      .full     (full)
   );

   assign irq_req = win_valid && (win_idx < cur_lvl) && !full;
   assign irq_vec = win_idx;
   assign wake    = (|masked) || ext_wake;
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
   parameter int DEPTH = 4,
   parameter int DW    = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          irq_req,
   input logic [2:0]    irq_vec,
   input logic          irq_ack,
   input logic          irq_ret,
   input logic [DW-1:0] nest_depth,
   input logic [4:0]    src_en,
   input logic          wake,
   input logic [2:0]    cur_lvl
);
   assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      nest_depth <= DW'(DEPTH));

   assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (nest_depth == DW'(DEPTH)) |-> !irq_req);

   assert_ack_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack && !irq_ret) |=> (nest_depth == $past(nest_depth) + 1'b1));

   assert_ret_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && nest_depth != '0) |=> (nest_depth == $past(nest_depth) - 1'b1));

   assert_ret_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && nest_depth == '0) |=> (nest_depth == '0));

   assert_enabled_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (((src_en >> irq_vec) & 5'd1) != 5'd0));

   assert_strict_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec < cur_lvl));

   assert_wake_on_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> wake);
endmodule

bind irq_nest_ctrl irq_nest_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_req    (irq_req),
   .irq_vec    (irq_vec),
   .irq_ack    (irq_ack),
   .irq_ret    (irq_ret),
   .nest_depth (nest_depth),
   .src_en     (src_en),
   .wake       (wake),
   .cur_lvl    (cur_lvl)
);

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;
   localparam int DIV = 3;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] ext_pin;
   logic [1:0] ext_rise_sel;
   logic       ser_done;
   logic [1:0] tmr_run;
   logic [2:0] tmr0_sel, tmr1_sel;
   logic [4:0] src_en;
   logic       irq_ack, irq_ret, ext_wake;
   logic       irq_req;
   logic [2:0] irq_vec;
   logic [2:0] nest_depth;
   logic       wake;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   irq_nest_ctrl #(.DEPTH(4), .TICK_DIV(DIV), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_rise_sel(ext_rise_sel),
      .ser_done(ser_done), .tmr_run(tmr_run), .tmr0_sel(tmr0_sel), .tmr1_sel(tmr1_sel),
      .src_en(src_en), .irq_ack(irq_ack), .irq_ret(irq_ret), .ext_wake(ext_wake),
      .irq_req(irq_req), .irq_vec(irq_vec), .nest_depth(nest_depth), .wake(wake)
   );

   typedef struct packed {
      logic [2:0]  sel;
      logic [15:0] cyc;
   } tv_t;

   // period code -> expected clocks between requests (DIV * tick multiple)
   localparam tv_t TV [8] = '{
      '{3'd0, 16'd3},   '{3'd1, 16'd30},   '{3'd2, 16'd60},   '{3'd3, 16'd150},
      '{3'd4, 16'd300}, '{3'd5, 16'd1500}, '{3'd6, 16'd3750}, '{3'd7, 16'd7500}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_ack();
      irq_ack = 1'b1; step(1); irq_ack = 1'b0;
   endtask

   task automatic pulse_ret();
      irq_ret = 1'b1; step(1); irq_ret = 1'b0;
   endtask

   task automatic pin_set(input int i, input logic v);
      ext_pin[i] = v; step(4);
   endtask

   task automatic ser_pulse();
      ser_done = 1'b1; step(1); ser_done = 1'b0; step(1);
   endtask

   task automatic measure(input string tag, input int exp_cyc, input int exp_vec);
      int n;
      n = 0;
      while (!irq_req && n < 20000) begin step(1); n++; end
      chk({tag, " vec"}, int'(irq_vec), exp_vec);
      pulse_ack();
      pulse_ret();
      n = 2;
      while (!irq_req && n < 20000) begin step(1); n++; end
      chk({tag, " interval"}, n, exp_cyc);
   endtask

   task automatic drain();
      tmr_run = 2'b00;
      step(4);
      for (int k = 0; k < 8; k++) begin
         if (irq_req) begin pulse_ack(); pulse_ret(); end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ext_pin = 2'b00; ext_rise_sel = 2'b01; ser_done = 1'b0;
      tmr_run = 2'b00; tmr0_sel = 3'd0; tmr1_sel = 3'd0; src_en = 5'b00000;
      irq_ack = 1'b0; irq_ret = 1'b0; ext_wake = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      chk("R1 req", irq_req, 0);
      chk("R1 depth", nest_depth, 0);
      chk("R1 wake", wake, 0);

      // R10 period table walk on timer 0
      src_en = 5'b01000;
      foreach (TV[k]) begin
         tmr0_sel = TV[k].sel;
         tmr_run  = 2'b01;
         measure($sformatf("R10 sel%0d", TV[k].sel), int'(TV[k].cyc), 3);
         drain();
      end

      // R10 timer 1 uses its own select
      src_en = 5'b10000; tmr1_sel = 3'd1;
      tmr_run = 2'b10;
      measure("R10 timer1", 30, 4);
      drain();

      // R12 stopped timer stays silent
      src_en = 5'b11111; tmr0_sel = 3'd0; tmr1_sel = 3'd0; tmr_run = 2'b00;
      step(50);
      chk("R12 no req", irq_req, 0);

      // R11 external wake
      ext_wake = 1'b1; #1;
      chk("R11 ext wake", wake, 1);
      ext_wake = 1'b0; #1;
      chk("R11 wake idle", wake, 0);

      // R2 rising edge on pin 0
      pin_set(0, 1'b1);
      chk("R2 rise req", irq_req, 1);
      chk("R2 rise vec", irq_vec, 0);
      chk("R11 wake pend", wake, 1);
      pulse_ack();
      chk("R6 depth", nest_depth, 1);
      chk("R6 flag cleared", irq_req, 0);
      pulse_ret();
      chk("R9 depth back", nest_depth, 0);
      chk("R6 no refire", irq_req, 0);

      // R2 opposite edge ignored
      pin_set(0, 1'b0);
      chk("R2 fall ignored", irq_req, 0);
      pin_set(1, 1'b1);
      chk("R2 rise ignored pin1", irq_req, 0);
      chk("R2 wake quiet", wake, 0);

      // R3 polarity change at constant level
      ext_rise_sel = 2'b10; step(4);
      chk("R3 polarity flip", irq_req, 0);
      chk("R3 wake", wake, 0);
      ext_rise_sel = 2'b00; step(4);
      chk("R3 polarity back", irq_req, 0);
      pin_set(1, 1'b0);
      chk("R2 fall req", irq_req, 1);
      chk("R2 fall vec", irq_vec, 1);
      pulse_ack(); pulse_ret();

      // R4 R5 R7 priority and masking
      src_en = 5'b00000; ext_rise_sel = 2'b11;
      pin_set(0, 1'b1);
      pin_set(1, 1'b1);
      ser_pulse();
      chk("R5 masked req", irq_req, 0);
      chk("R11 masked wake", wake, 0);
      src_en = 5'b00110; #1;
      chk("R5 mask pin0 vec", irq_vec, 1);
      chk("R5 mask pin0 req", irq_req, 1);
      src_en = 5'b11111; #1;
      chk("R4 top vec", irq_vec, 0);
      step(1);
      pulse_ack();
      chk("R7 lower held", irq_req, 0);
      pulse_ret();
      chk("R4 next vec", irq_vec, 1);
      pulse_ack();
      chk("R7 ser held", irq_req, 0);
      pin_set(0, 1'b0);
      pin_set(0, 1'b1);
      chk("R7 preempt req", irq_req, 1);
      chk("R7 preempt vec", irq_vec, 0);
      pulse_ack();
      chk("R6 depth2", nest_depth, 2);
      pulse_ret();
      chk("R9 restore level", irq_req, 0);
      pulse_ret();
      chk("R4 ser vec", irq_vec, 2);
      chk("R4 ser req", irq_req, 1);
      pulse_ack(); pulse_ret();
      chk("R4 all served", irq_req, 0);
      pin_set(0, 1'b0);
      pin_set(1, 1'b0);

      // R8 depth limit
      src_en = 5'b00000; tmr_run = 2'b11;
      step(10);
      tmr_run = 2'b00;
      step(3);
      chk("R8 timers masked", irq_req, 0);
      src_en = 5'b10000; #1;
      chk("R8 t1 vec", irq_vec, 4);
      step(1); pulse_ack();
      src_en = 5'b11000; #1;
      chk("R8 t0 vec", irq_vec, 3);
      step(1); pulse_ack();
      src_en = 5'b11111;
      ser_pulse();
      chk("R8 ser vec", irq_vec, 2);
      pulse_ack();
      pin_set(1, 1'b1);
      chk("R8 pin1 vec", irq_vec, 1);
      pulse_ack();
      chk("R8 depth4", nest_depth, 4);
      pin_set(0, 1'b1);
      chk("R8 full blocks", irq_req, 0);
      chk("R11 wake at full", wake, 1);
      pulse_ret();
      chk("R9 depth3", nest_depth, 3);
      chk("R8 released vec", irq_vec, 0);
      chk("R8 released req", irq_req, 1);
      pulse_ack();
      chk("R8 depth4 again", nest_depth, 4);
      for (int k = 0; k < 4; k++) pulse_ret();
      chk("R9 unwound", nest_depth, 0);
      pulse_ret();
      chk("R9 empty ret", nest_depth, 0);
      chk("R9 nothing left", irq_req, 0);
      pin_set(0, 1'b0);
      pin_set(1, 1'b0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule